// File: doc/BRIEF.md
# Active-Video Window and BT.656 Stream Generator

This block takes a pixel clock, horizontal and vertical sync inputs and a pixel word stream. It marks the active picture with a data-enable output. The active window is placed by a programmable pixel delay, counted from the HSYNC leading edge, and a programmable line delay, counted from the VSYNC leading edge. A programmable line width and screen height set its size. For interlaced sources, the second field can start a programmable number of lines later than the first.

When the embedded-timing mode is on, the output stream becomes a BT.656-style stream. Every line carries a start-of-active-video code just before the window and an end-of-active-video code just after it. Blanking words are filled in between the codes. All settings arrive as plain parallel inputs. Both sync inputs are synchronised internally, so they may come from another clock.

Top module: `active_window_gen`

## Requirements
- R1: A sync leading edge is a low-to-high change seen after a two-flop synchroniser. The output for horizontal position k (position 0 being the first position after the HSYNC edge) leaves the block on the (k+4)-th rising clock edge, counting the edge that first samples HSYNC high as edge 1.
- R2: With internal generation selected (`forceDe`=1), `deOut` is high on an active line for exactly `lineWidth` consecutive clocks, at horizontal positions `hDelay` to `hDelay+lineWidth-1`.
- R3: Lines are numbered from the VSYNC leading edge. The line whose HSYNC edge is sampled together with the VSYNC edge is line 0, and each later HSYNC edge adds one. Only lines `vDelay` to `vDelay+screenHeight-1` are active; on every other line `deOut` stays low.
- R4: With `ilaceEn`=1, the field flag toggles at every VSYNC leading edge. It is 0 after reset, so the first frame after reset is field 1. In field 1 the active lines start `ilaceOff` lines later. With `ilaceEn`=0 the field is held at 0.
- R5: With `forceDe`=0, `deOut` is `deIn` delayed by one clock, whatever the window settings.
- R6: With `bt656En`=1 and `hDelay`>=4, the four words just before the first active position of every line are 0x3FF, 0x000, 0x000, XY with H=0. XY is laid out as follows: bit 9 is 1, bit 8 is F (field), bit 7 is V (1 on lines outside the active range), bit 6 is H, bits 5..2 are V^H, F^H, F^V and F^V^H, and bits 1..0 are 0.
- R7: With `bt656En`=1, the four words just after the last active position of every line are 0x3FF, 0x000, 0x000, XY with H=1, using the same XY layout as R6.
- R8: With `bt656En`=1, every other word outside the codes and the active window is a blanking level: 0x200 at even horizontal positions and 0x040 at odd ones.
- R9: In the active window, and on every cycle when `bt656En`=0, `dataOut` equals `pixIn` delayed by one clock. A narrower `DATA_W` keeps the upper bits of every 10-bit code and level.
- R10: While reset is asserted and until the first sync edge, `deOut` is 0. While reset is asserted, `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Horizontal sync, active high |
| vsyncIn | input | 1 | Vertical sync, active high |
| deIn | input | 1 | External data enable, used when forceDe=0 |
| pixIn | input | DATA_W | Incoming pixel words |
| hDelay | input | HDLY_W | Pixels from HSYNC edge to first active pixel |
| vDelay | input | VDLY_W | Lines from VSYNC edge to first active line |
| lineWidth | input | SIZE_W | Active pixels per line |
| screenHeight | input | SIZE_W | Active lines per field |
| ilaceEn | input | 1 | Interlace: toggle field at each VSYNC |
| ilaceOff | input | ILOFF_W | Line shift of field 1 |
| forceDe | input | 1 | Generate deOut from the programmed window |
| bt656En | input | 1 | Embed timing codes and blanking in dataOut |
| deOut | output | 1 | Data enable, registered |
| dataOut | output | DATA_W | Output word stream, registered |

## Verification
The bench drives whole frames and checks every output word against a scoreboard built from the requirements. The cases are chosen to catch specific mistakes:
- An off-by-one in the sync latency or the window compare would shift or stretch `deOut` by one clock at the line edges.
- An odd line width is used, so a design that counts blanking parity from the window instead of from the sync edge would swap the 0x200 and 0x040 levels.
- Two interlaced frames are run, so a wrong field toggle or a missing line offset would flip F or V in the codes, break the protection bits, and move the active lines in one of the two fields.
- A final frame with external enable shows whether the window leaks into `deOut` when it should not.

// File: rtl/awg_pkg.sv
package awg_pkg;

  // Per-cycle strobes from the timing control to the stream datapath.
  typedef struct packed {
    logic       winDe;       // inside horizontal and vertical window
    logic       savSlot;     // one of the four words before the window
    logic       eavSlot;     // one of the four words after the window
    logic [1:0] codeIdx;     // word index inside the timing code
    logic       vBlank;      // line lies outside the active line range
    logic       field;       // current field flag
    logic       chromaPhase; // even horizontal position
  } awgStrobeT;

  localparam int CODE_LEN = 4;
  localparam logic [9:0] TRS_PREAMBLE = 10'h3FF;
  localparam logic [9:0] LVL_CHROMA   = 10'h200;
  localparam logic [9:0] LVL_LUMA     = 10'h040;

  // Fourth word of a timing reference code, 10-bit form.
  function automatic logic [9:0] trsStatus(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

endpackage

// File: rtl/awg_sync.sv
module awg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/awg_timing.sv
module awg_timing
  import awg_pkg::*;
#(
  parameter int HDLY_W      = 10,
  parameter int VDLY_W      = 6,
  parameter int SIZE_W      = 12,
  parameter int ILOFF_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  input  logic [HDLY_W-1:0]  hDelay,
  input  logic [VDLY_W-1:0]  vDelay,
  input  logic [SIZE_W-1:0]  lineWidth,
  input  logic [SIZE_W-1:0]  screenHeight,
  input  logic               ilaceEn,
  input  logic [ILOFF_W-1:0] ilaceOff,
  output awgStrobeT          stb
);

  localparam int MAXW = (SIZE_W > HDLY_W) ? SIZE_W : HDLY_W;
  localparam int CW   = MAXW + 2;  // room for delay + size + code length
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic hsS, vsS, hsQ, vsQ, hRise, vRise;

  awg_sync #(.STAGES(SYNC_STAGES)) u_hsSync (.clk(clk), .rstN(rstN), .din(hsyncIn), .dout(hsS));
  awg_sync #(.STAGES(SYNC_STAGES)) u_vsSync (.clk(clk), .rstN(rstN), .din(vsyncIn), .dout(vsS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsQ <= 1'b0;
      vsQ <= 1'b0;
    end else begin
      hsQ <= hsS;
      vsQ <= vsS;
    end
  end

  assign hRise = hsS & ~hsQ;
  assign vRise = vsS & ~vsQ;

  // Pixel and line counters; saturate so a missing sync never wraps into a window.
  logic [CW-1:0] hCnt, vCnt;
  logic          field;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hCnt <= CNT_MAX;
    else if (hRise)            hCnt <= '0;
    else if (hCnt != CNT_MAX)  hCnt <= hCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          vCnt <= CNT_MAX;
    else if (vRise)                     vCnt <= '0;
    else if (hRise && vCnt != CNT_MAX)  vCnt <= vCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         field <= 1'b0;
    else if (!ilaceEn) field <= 1'b0;
    else if (vRise)    field <= ~field;
  end

  // Window bounds
  logic [CW-1:0] hStart, hEnd, vStart, vEnd;
  logic [CW:0]   hCntAhead, hEndTail;
  logic          hAct, vAct;

  assign hStart    = CW'(hDelay);
  assign hEnd      = hStart + CW'(lineWidth);
  assign vStart    = CW'(vDelay) + (field ? CW'(ilaceOff) : '0);
  assign vEnd      = vStart + CW'(screenHeight);
  assign hCntAhead = {1'b0, hCnt} + (CW+1)'(CODE_LEN);
  assign hEndTail  = {1'b0, hEnd} + (CW+1)'(CODE_LEN);

  assign hAct = (hCnt >= hStart) && (hCnt < hEnd);
  assign vAct = (vCnt >= vStart) && (vCnt < vEnd);

  always_comb begin
    stb.winDe       = hAct && vAct;
    stb.savSlot     = (hCntAhead >= {1'b0, hStart}) && (hCnt < hStart);
    stb.eavSlot     = (hCnt >= hEnd) && ({1'b0, hCnt} < hEndTail);
    stb.codeIdx     = stb.savSlot ? (hCnt[1:0] - hStart[1:0]) : (hCnt[1:0] - hEnd[1:0]);
    stb.vBlank      = ~vAct;
    stb.field       = field;
    stb.chromaPhase = ~hCnt[0];
  end

  // R4: the field flag only moves on a VSYNC leading edge while interlace is on
  p_field_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ilaceEn && !vRise) |=> $stable(field));

endmodule

// File: rtl/awg_stream.sv
module awg_stream
  import awg_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  awgStrobeT         stb,
  input  logic              bt656En,
  input  logic              forceDe,
  input  logic              deIn,
  input  logic [DATA_W-1:0] pixIn,
  output logic              deOut,
  output logic [DATA_W-1:0] dataOut
);

  localparam int HBIT = DATA_W - 4;  // position of H inside the status word

  logic [9:0]        codeWord, levelWord;
  logic [DATA_W-1:0] nxtData;
  logic              nxtDe;

  always_comb begin
    case (stb.codeIdx)
      2'd0:    codeWord = TRS_PREAMBLE;
      2'd3:    codeWord = trsStatus(stb.field, stb.vBlank, stb.eavSlot);
      default: codeWord = '0;
    endcase
    levelWord = stb.chromaPhase ? LVL_CHROMA : LVL_LUMA;

    if (!bt656En)                        nxtData = pixIn;
    else if (stb.savSlot || stb.eavSlot) nxtData = codeWord[9 -: DATA_W];
    else if (stb.winDe)                  nxtData = pixIn;
    else                                 nxtData = levelWord[9 -: DATA_W];

    nxtDe = forceDe ? stb.winDe : deIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deOut   <= 1'b0;
      dataOut <= '0;
    end else begin
      deOut   <= nxtDe;
      dataOut <= nxtData;
    end
  end

  // R6: the word just before a generated window opens is a status word with H=0
  p_sav_lead_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(deOut) && forceDe && bt656En && $past(forceDe) && $past(bt656En))
      |-> ($past(dataOut[DATA_W-1]) && !$past(dataOut[HBIT])));

  // R7: the first word after a generated window is the all-ones preamble
  p_eav_trail_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(deOut) && forceDe && bt656En && $past(forceDe) && $past(bt656En))
      |-> (dataOut == '1));

endmodule

// File: rtl/active_window_gen.sv
module active_window_gen
  import awg_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int HDLY_W      = 10,
  parameter int VDLY_W      = 6,
  parameter int SIZE_W      = 12,
  parameter int ILOFF_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hsyncIn,
  input  logic               vsyncIn,
  input  logic               deIn,
  input  logic [DATA_W-1:0]  pixIn,
  input  logic [HDLY_W-1:0]  hDelay,
  input  logic [VDLY_W-1:0]  vDelay,
  input  logic [SIZE_W-1:0]  lineWidth,
  input  logic [SIZE_W-1:0]  screenHeight,
  input  logic               ilaceEn,
  input  logic [ILOFF_W-1:0] ilaceOff,
  input  logic               forceDe,
  input  logic               bt656En,
  output logic               deOut,
  output logic [DATA_W-1:0]  dataOut
);

  awgStrobeT stb;

  awg_timing #(
    .HDLY_W(HDLY_W), .VDLY_W(VDLY_W), .SIZE_W(SIZE_W),
    .ILOFF_W(ILOFF_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_timing (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .hDelay(hDelay), .vDelay(vDelay), .lineWidth(lineWidth),
    .screenHeight(screenHeight), .ilaceEn(ilaceEn), .ilaceOff(ilaceOff),
    .stb(stb)
  );

  awg_stream #(.DATA_W(DATA_W)) u_stream (
    .clk(clk), .rstN(rstN), .stb(stb), .bt656En(bt656En), .forceDe(forceDe),
    .deIn(deIn), .pixIn(pixIn), .deOut(deOut), .dataOut(dataOut)
  );

  // Run-length counter of deOut, used only by the R2 properties.
  logic [SIZE_W:0] deRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     deRun <= '0;
    else if (!deOut)               deRun <= '0;
    else if (deRun != '1)          deRun <= deRun + 1'b1;
  end

  // R2: a generated enable never stays high longer than lineWidth
  p_de_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    (deOut && forceDe) |-> (deRun < {1'b0, lineWidth}));

  // R2: and when it drops it has been high for exactly lineWidth clocks
  p_de_run_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(deOut) && forceDe && $past(forceDe)) |-> (deRun == {1'b0, lineWidth}));

endmodule

// File: tb/active_window_gen_tb.sv
module active_window_gen_tb_top;

  localparam int DW        = 10;
  localparam int LINE_CLKS = 40;
  localparam int FRAME_LN  = 12;
  localparam int WATCHDOG  = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncIn = 1'b0, vsyncIn = 1'b0, deIn = 1'b0;
  logic [DW-1:0] pixIn = '0;
  logic deOut;
  logic [DW-1:0] dataOut;

  int cHd = 10, cW = 16, cVd = 3, cH = 4, cOff = 0;
  bit cIlace = 0, cForce = 1, cBt = 0, deInOn = 0, fieldB = 0;

  logic [9:0]  hDelay;
  logic [5:0]  vDelay;
  logic [11:0] lineWidth, screenHeight;
  logic [2:0]  ilaceOff;

  assign hDelay       = 10'(cHd);
  assign vDelay       = 6'(cVd);
  assign lineWidth    = 12'(cW);
  assign screenHeight = 12'(cH);
  assign ilaceOff     = 3'(cOff);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  active_window_gen dut_i (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .deIn(deIn),
    .pixIn(pixIn), .hDelay(hDelay), .vDelay(vDelay), .lineWidth(lineWidth),
    .screenHeight(screenHeight), .ilaceEn(cIlace), .ilaceOff(ilaceOff),
    .forceDe(cForce), .bt656En(cBt), .deOut(deOut), .dataOut(dataOut)
  );

  function automatic logic [DW-1:0] pixPat(input int c);
    return DW'(c * 37 + 5);
  endfunction

  function automatic logic deInPat(input int c);
    return c[2];
  endfunction

  always @(negedge clk) begin
    pixIn <= pixPat(cyc);
    deIn  <= deInOn & deInPat(cyc);
  end

  typedef struct {
    int            cyc;
    logic          de;
    logic [DW-1:0] data;
    string         deTag;
    string         dataTag;
  } itemT;

  itemT expQ[$];
  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Driver side: expected words for one line, from the requirements.
  task automatic pushLine(input int d, input int v);
    int vs;
    bit vAct;
    vs   = cVd + (fieldB ? cOff : 0);
    vAct = (v >= vs) && (v < vs + cH);
    for (int k = 0; k < LINE_CLKS; k++) begin
      itemT it2;
      bit hAct, sav, eav, vb, h;
      int idx;
      logic [9:0] w;
      int s;
      s    = d + 4 + k;                         // R1 latency
      hAct = (k >= cHd) && (k < cHd + cW);
      sav  = (k >= cHd - 4) && (k < cHd);
      eav  = (k >= cHd + cW) && (k < cHd + cW + 4);
      vb   = !vAct;
      h    = eav;
      idx  = sav ? (k - cHd + 4) : (k - cHd - cW);
      it2.cyc = s;
      if (!cForce) begin
        it2.de = deInOn & deInPat(s - 1);
        it2.deTag = "R5";
      end else begin
        it2.de = hAct && vAct;
        if (cIlace)           it2.deTag = "R4";
        else if (k == cHd)    it2.deTag = "R1";
        else if (vAct)        it2.deTag = "R2";
        else                  it2.deTag = "R3";
      end
      if (!cBt) begin
        it2.data = pixPat(s - 1);
        it2.dataTag = "R9";
      end else if (sav || eav) begin
        if (idx == 0)      w = 10'h3FF;
        else if (idx == 3) w = {1'b1, fieldB, vb, h, vb ^ h, fieldB ^ h, fieldB ^ vb, fieldB ^ vb ^ h, 2'b00};
        else               w = 10'h000;
        it2.data = w[9 -: DW];
        it2.dataTag = sav ? "R6" : "R7";
      end else if (hAct && vAct) begin
        it2.data = pixPat(s - 1);
        it2.dataTag = "R9";
      end else begin
        w = (k % 2 == 0) ? 10'h200 : 10'h040;
        it2.data = w[9 -: DW];
        it2.dataTag = "R8";
      end
      expQ.push_back(it2);
    end
  endtask

  task automatic driveLine(input int v);
    if (v == 0) fieldB = cIlace ? ~fieldB : 1'b0;
    pushLine(cyc, v);
    for (int j = 0; j < LINE_CLKS; j++) begin
      hsyncIn = (j < 4);
      vsyncIn = (v < 2);
      @(negedge clk);
    end
  endtask

  task automatic runFrame();
    for (int ln = 0; ln < FRAME_LN; ln++) driveLine(ln);
  endtask

  task automatic idle(input int n);
    hsyncIn = 1'b0;
    vsyncIn = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor side: pop and compare as the design produces words.
  itemT got;
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      got = expQ.pop_front();
      checks += 2;
      if (got.cyc != cyc) begin
        errors++;
        $display("FAIL R1 scoreboard slot missed: actual cyc=%0d expected cyc=%0d", cyc, got.cyc);
      end
      if (deOut !== got.de) begin
        errors++;
        $display("FAIL %s cyc=%0d deOut actual=%b expected=%b", got.deTag, cyc, deOut, got.de);
      end
      if (dataOut !== got.data) begin
        errors++;
        $display("FAIL %s cyc=%0d dataOut actual=%h expected=%h", got.dataTag, cyc, dataOut, got.data);
      end
    end
  end

  task automatic checkIdle(input string tag);
    checks++;
    if (deOut !== 1'b0 || (!rstN && dataOut !== '0)) begin
      errors++;
      $display("FAIL %s reset state: actual de=%b data=%h expected de=0 data=0", tag, deOut, dataOut);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R10");                 // R10 during reset
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R10");                 // R10 before any sync edge

    // Phase 1: generated enable, plain pass-through data
    cHd = 10; cW = 16; cVd = 3; cH = 4; cOff = 0;
    cIlace = 0; cForce = 1; cBt = 0;
    runFrame();
    idle(10);

    // Phase 2: embedded codes, odd width (R6 R7 R8 parity)
    cHd = 6; cW = 9; cVd = 2; cH = 5;
    cBt = 1;
    runFrame();
    idle(10);

    // Phase 3: interlace with field 1 shifted by two lines, two frames
    cHd = 8; cW = 12; cVd = 2; cH = 3; cOff = 2;
    cIlace = 1;
    runFrame();
    runFrame();
    idle(10);

    // Phase 4: external enable passed through (R5)
    cIlace = 0; cForce = 0; cBt = 0; deInOn = 1;
    cHd = 10; cW = 16; cVd = 3; cH = 4; cOff = 0;
    runFrame();
    idle(10);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1 leftover expected words: actual=%0d expected=0", expQ.size());
    end
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

endmodule